// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Engine

This block keeps an 8-bit stack pointer into an internal byte RAM and carries out push and pop requests for a CPU. The stack grows towards higher addresses. The pointer always names the byte that was stored most recently. A push therefore moves the pointer up first and then writes the byte at the new address. A pop reads the byte under the pointer first and then moves the pointer down. After reset the pointer holds 07h, so the first byte pushed lands at address 08h.

The engine drives a single-port synchronous RAM through an address, a write-data bus, a write enable and a read-data return. The RAM address output is the pointer itself. Each push or pop takes two clock cycles and ends with a one-cycle done pulse. Software can load the pointer directly at any time and can always read it back.

Top module: `stack_ptr_engine`

## Requirements
- R1: While reset is high and in the cycle after it, sp_value is 07h and done, busy and ram_we are 0.
- R2: An accepted push raises sp_value by one at the accept edge. In the next cycle busy=1, ram_we=1, ram_addr equals the new pointer and ram_wdata equals the pushed byte. In the cycle after that done=1 and ram_we=0.
- R3: An accepted pop gives busy=1 and ram_we=0 in the next cycle. In the cycle after that done=1, pop_data holds the byte stored at the pointer's value when the pop was accepted, and sp_value is that value minus one.
- R4: A push from FFh wraps the pointer to 00h and writes address 00h.
- R5: A pop at 00h leaves the pointer at FFh.
- R6: While busy is 1, push and pop requests are ignored: they produce no second write and no extra pointer change.
- R7: sp_wr_en=1 in the same idle cycle as a push or pop request loads the pointer and discards the request. No write, no busy and no done follow.
- R8: A direct write loads sp_wr_data into the pointer at the next edge, and sp_value shows it from then on.
- R9: When push and pop are requested together while idle, the push is carried out.
- R10: A series of pushes followed by as many pops returns the bytes in reverse order and restores the starting pointer.
- R11: A direct write during the final cycle of a pop sets the pointer to the loaded value. The pop still finishes with done and the byte that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request, sampled while idle |
| push_data | input | DATA_W | Byte to push |
| pop_req | input | 1 | Pop request, sampled while idle |
| pop_data | output | DATA_W | Byte returned by the last pop |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An operation is in flight |
| sp_wr_en | input | 1 | Direct pointer write strobe |
| sp_wr_data | input | ADDR_W | Value for a direct pointer write |
| sp_value | output | ADDR_W | Current stack pointer |
| ram_addr | output | ADDR_W | RAM address (the pointer) |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | DATA_W | Synchronous RAM read data |

## Verification
A wrong pointer shows up on sp_value and ram_addr at the first edge after the faulty update. A write from a stale pointer shows up one cycle after the accept edge, because the address then disagrees with the previous pointer plus one. A pointer that drifts by one shows up on the next pop as wrong returned data. The pointer is loaded to every one of the 256 values and a push and pop is run at each one, so any error in the increment, the decrement or the wrap is caught within three cycles of that pointer value.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_WR,
    ST_POP_CAP
  } stk_state_e;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_INC,
    PTR_DEC,
    PTR_LOAD
  } ptr_op_e;
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg
  import stk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RST_VAL = 'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  // Arithmetic is modulo 2**ADDR_W, so both directions wrap naturally.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= RST_VAL;
    end else begin
      case (op)
        PTR_INC:  ptr <= ptr + STEP;
        PTR_DEC:  ptr <= ptr - STEP;
        PTR_LOAD: ptr <= load_val;
        default:  ptr <= ptr;
      endcase
    end
  end

  a_r5_dec_wraps_to_top: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_DEC && ptr == '0) |=> ptr == '1);
  a_r4_inc_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_INC && ptr == '1) |=> ptr == '0);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    sp_wr_en,
  output ptr_op_e ptr_op,
  output logic    launch_push,
  output logic    capture_pop,
  output logic    ram_we,
  output logic    done,
  output logic    busy
);
  stk_state_e state, state_nx;
  logic       finish;

  always_comb begin
    state_nx    = state;
    ptr_op      = PTR_HOLD;
    launch_push = 1'b0;
    capture_pop = 1'b0;
    finish      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sp_wr_en) begin
          ptr_op = PTR_LOAD;
        end else if (push_req) begin
          ptr_op      = PTR_INC;
          launch_push = 1'b1;
          state_nx    = ST_PUSH_WR;
        end else if (pop_req) begin
          state_nx = ST_POP_CAP;
        end
      end
      ST_PUSH_WR: begin
        ptr_op   = sp_wr_en ? PTR_LOAD : PTR_HOLD;
        finish   = 1'b1;
        state_nx = ST_IDLE;
      end
      ST_POP_CAP: begin
        ptr_op      = sp_wr_en ? PTR_LOAD : PTR_DEC;
        capture_pop = 1'b1;
        finish      = 1'b1;
        state_nx    = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ram_we <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= state_nx;
      ram_we <= launch_push;
      done   <= finish;
    end
  end

  assign busy = (state != ST_IDLE);

  a_r2_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
  a_r6_pop_never_writes: assert property (@(posedge clk) disable iff (rst)
    (busy && !ram_we) |=> !ram_we);
endmodule

// File: rtl/stk_dpath.sv
module stk_dpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_push,
  input  logic              capture_pop,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [DATA_W-1:0] pop_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_wdata <= '0;
      pop_data  <= '0;
    end else begin
      if (launch_push) ram_wdata <= push_data;
      if (capture_pop) pop_data  <= ram_rdata;
    end
  end
endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
  import stk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              done,
  output logic              busy,
  input  logic              sp_wr_en,
  input  logic [ADDR_W-1:0] sp_wr_data,
  output logic [ADDR_W-1:0] sp_value,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  ptr_op_e ptr_op;
  logic    launch_push;
  logic    capture_pop;

  stk_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .sp_wr_en   (sp_wr_en),
    .ptr_op     (ptr_op),
    .launch_push(launch_push),
    .capture_pop(capture_pop),
    .ram_we     (ram_we),
    .done       (done),
    .busy       (busy)
  );

  stk_ptr_reg #(
    .ADDR_W (ADDR_W),
    .RST_VAL(SP_RESET)
  ) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .op      (ptr_op),
    .load_val(sp_wr_data),
    .ptr     (sp_value)
  );

  stk_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .launch_push(launch_push),
    .capture_pop(capture_pop),
    .push_data  (push_data),
    .ram_rdata  (ram_rdata),
    .ram_wdata  (ram_wdata),
    .pop_data   (pop_data)
  );

  // The pointer register drives the RAM address directly, so the RAM always
  // sees the top of the stack and a pop needs no extra address cycle.
  assign ram_addr = sp_value;

  a_r8_load_visible: assert property (@(posedge clk) disable iff (rst)
    sp_wr_en |=> sp_value == $past(sp_wr_data));
  a_r2_push_steps_up: assert property (@(posedge clk) disable iff (rst)
    (!busy && push_req && !sp_wr_en) |=> sp_value == ADDR_W'($past(sp_value) + ONE));
  a_r2_done_follows_write: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> done);
  a_r1_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_load_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && sp_wr_en) |=> !busy);
endmodule

// File: tb/stack_ptr_engine_tb.sv
module stack_ptr_engine_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic          push_req, pop_req, sp_wr_en;
  logic [DW-1:0] push_data, pop_data, ram_wdata, ram_rdata;
  logic [AW-1:0] sp_wr_data, sp_value, ram_addr;
  logic          done, busy, ram_we;

  stack_ptr_engine u_dut (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .push_data (push_data),
    .pop_req   (pop_req),
    .pop_data  (pop_data),
    .done      (done),
    .busy      (busy),
    .sp_wr_en  (sp_wr_en),
    .sp_wr_data(sp_wr_data),
    .sp_value  (sp_value),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_rdata (ram_rdata)
  );

  // Synchronous single-port RAM model.
  logic [DW-1:0] mem [0:DEPTH-1];
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_sp;
  logic [DW-1:0] ref_mem [0:DEPTH-1];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = AW'(v);
    @(negedge clk);
    sp_wr_en = 1'b0;
    exp_sp = v;
    chk("R8 sp after load", sp_value, exp_sp);
  endtask

  task automatic do_push(input logic [DW-1:0] d);
    int nsp;
    nsp = (exp_sp + 1) % DEPTH;
    @(negedge clk);
    push_req = 1'b1; push_data = d;
    @(negedge clk);
    push_req = 1'b0;
    chk("R2 we in write cycle", ram_we, 1);
    chk("R2 R4 write address", ram_addr, nsp);
    chk("R2 write data", ram_wdata, d);
    chk("R2 busy", busy, 1);
    @(negedge clk);
    chk("R2 done", done, 1);
    chk("R2 we dropped", ram_we, 0);
    chk("R2 R4 sp after push", sp_value, nsp);
    exp_sp = nsp;
    ref_mem[exp_sp] = d;
  endtask

  task automatic do_pop();
    int nsp;
    nsp = (exp_sp + DEPTH - 1) % DEPTH;
    @(negedge clk);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    chk("R3 busy", busy, 1);
    chk("R3 no write", ram_we, 0);
    @(negedge clk);
    chk("R3 done", done, 1);
    chk("R3 R10 pop data", pop_data, ref_mem[exp_sp]);
    chk("R3 R5 sp after pop", sp_value, nsp);
    exp_sp = nsp;
  endtask

  initial begin
    rst = 1'b1; push_req = 0; pop_req = 0; sp_wr_en = 0;
    push_data = '0; sp_wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 sp reset", sp_value, 'h07);
    chk("R1 done reset", done, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 we reset", ram_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sp after release", sp_value, 'h07);
    exp_sp = 'h07;

    // R10: LIFO order from the reset pointer; first byte lands at 08h.
    for (int i = 0; i < 20; i++) do_push(DW'(8'h30 + i));
    chk("R10 sp after pushes", sp_value, 'h07 + 20);
    for (int i = 19; i >= 0; i--) begin
      do_pop();
      chk("R10 reverse order", pop_data, 8'h30 + i);
    end
    chk("R10 sp restored", sp_value, 'h07);

    // R4 R5 sweep every pointer value.
    for (int v = 0; v < DEPTH; v++) begin
      do_load(v);
      do_push(DW'(v ^ 8'h5A));
      do_pop();
      chk("R4 R5 sweep sp", sp_value, v);
    end
    // R5: pop at 00h.
    do_load(0);
    do_pop();
    chk("R5 wrap to FF", sp_value, 'hFF);

    // R7: load together with push while idle.
    @(negedge clk);
    sp_wr_en = 1; sp_wr_data = 8'h40; push_req = 1; push_data = 8'hEE;
    @(negedge clk);
    sp_wr_en = 0; push_req = 0;
    exp_sp = 'h40;
    chk("R7 sp loaded", sp_value, 'h40);
    chk("R7 no busy", busy, 0);
    chk("R7 no write", ram_we, 0);
    @(negedge clk);
    chk("R7 no done", done, 0);
    chk("R7 sp unchanged", sp_value, 'h40);
    // R7: load together with pop.
    @(negedge clk);
    sp_wr_en = 1; sp_wr_data = 8'h90; pop_req = 1;
    @(negedge clk);
    sp_wr_en = 0; pop_req = 0;
    exp_sp = 'h90;
    chk("R7 pop discarded busy", busy, 0);
    @(negedge clk);
    chk("R7 pop discarded done", done, 0);
    chk("R7 pop discarded sp", sp_value, 'h90);

    // R9: simultaneous push and pop -> push.
    @(negedge clk);
    push_req = 1; pop_req = 1; push_data = 8'hC3;
    @(negedge clk);
    push_req = 0; pop_req = 0;
    chk("R9 write issued", ram_we, 1);
    chk("R9 write address", ram_addr, 'h91);
    @(negedge clk);
    chk("R9 sp up", sp_value, 'h91);
    exp_sp = 'h91; ref_mem['h91] = 8'hC3;
    do_pop();
    chk("R9 pushed byte", pop_data, 8'hC3);

    // R6: requests held during busy are ignored.
    @(negedge clk);
    push_req = 1; push_data = 8'h11;
    @(negedge clk);
    push_data = 8'h22; pop_req = 1;
    chk("R6 first data", ram_wdata, 8'h11);
    @(negedge clk);
    push_req = 0; pop_req = 0;
    chk("R6 single step", sp_value, 'h91);
    chk("R6 done", done, 1);
    @(negedge clk);
    chk("R6 no second op", busy, 0);
    chk("R6 no second write", ram_we, 0);
    chk("R6 sp held", sp_value, 'h91);
    exp_sp = 'h91; ref_mem['h91] = 8'h11;

    // R11: load during the final pop cycle.
    do_push(8'hA7);
    @(negedge clk);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0; sp_wr_en = 1; sp_wr_data = 8'h80;
    @(negedge clk);
    sp_wr_en = 0;
    chk("R11 done", done, 1);
    chk("R11 data", pop_data, 8'hA7);
    chk("R11 sp loaded", sp_value, 'h80);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule